// File: doc/BRIEF.md
# Scaler Phase Step Generator

This block drives the coordinate side of one axis of a display scaler. A configuration request gives a source length, a destination length, a chroma subsampling shift and a flag for YUV input. The block checks whether the ratio is legal. It then divides to get a fixed-point step: 26 bits wide, with a ratio of one equal to 2^21. It also derives a separate, smaller step for the chroma plane and chooses the interpolation filter. It records whether the scaler stage has to be engaged at all.

Once a legal configuration is loaded, a line-start pulse runs one output line. For every output pixel that the downstream interpolator accepts through a valid/ready handshake, the block presents two values for each of the luma and chroma planes: the integer source index and the 21-bit fractional phase. It then advances both phase accumulators by their steps. After the last pixel of the line, the block pulses a line-done flag.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, cfg_busy, cfg_done, cfg_ok, err_zero, err_range, out_valid and line_done are 0, and both step outputs are 0.
- R2: An accepted request with legal lengths raises cfg_busy on the capture edge. cfg_done pulses for one cycle NUM_W+1 edges after the capture edge, where NUM_W = LEN_W+FRAC_W. At that point cfg_busy falls, cfg_ok is 1, and luma_step = floor(src * 2^21 / dst).
- R3: A source or destination length of zero sets err_zero and clears cfg_ok and both steps on the capture edge, with cfg_done high in the cycle that follows that edge and no busy period.
- R4: A nonzero request with src >= 32*dst (the quotient would not fit in 5 integer bits) is rejected the same way, with err_range set instead. The case src = 32*dst - 1 is accepted.
- R5: chroma_step equals luma_step shifted right by cfg_sub_shift (a subsampling factor of 2^cfg_sub_shift; 0 means 4:4:4).
- R6: filter_sel is 0 (bilinear) when src <= dst, and 1 (pixel coverage) otherwise.
- R7: scale_en is 1 when src differs from dst or cfg_is_yuv is 1, and 0 otherwise.
- R8: For output pixel k of a line (k from 0), luma_idx = floor(k*luma_step / 2^21) and luma_phase = (k*luma_step) mod 2^21. chroma_idx and chroma_phase follow the same rule with chroma_step.
- R9: out_valid is high from the cycle after an accepted line_start. One pixel advances per cycle in which out_valid and out_ready are both high, and all four pixel outputs hold steady while out_ready is low.
- R10: When the pixel count reaches dst, out_valid falls and line_done is high for exactly one cycle.
- R11: line_start has no effect, and out_valid stays 0, when no legal configuration is loaded or while a step is being computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_start | input | 1 | Request to load a new ratio; ignored while busy or while a line runs |
| cfg_src_len | input | LEN_W | Source length in pixels |
| cfg_dst_len | input | LEN_W | Destination length in pixels |
| cfg_sub_shift | input | 2 | Chroma subsampling factor as a power of two |
| cfg_is_yuv | input | 1 | Input is YUV |
| cfg_busy | output | 1 | Step division in progress |
| cfg_done | output | 1 | One-cycle pulse when a request finishes, legal or not |
| cfg_ok | output | 1 | A legal configuration is loaded |
| err_zero | output | 1 | Last request had a zero length |
| err_range | output | 1 | Last request exceeded the downscale limit |
| scale_en | output | 1 | Scaler stage must be engaged |
| filter_sel | output | 1 | 0 bilinear, 1 pixel coverage |
| luma_step | output | STEP_W | Luma phase step, unity = 2^FRAC_W |
| chroma_step | output | STEP_W | Chroma phase step |
| line_start | input | 1 | Begin one output line |
| out_ready | input | 1 | Consumer accepts the current pixel |
| out_valid | output | 1 | Pixel coordinates are valid |
| luma_idx | output | LEN_W | Luma integer source index |
| luma_phase | output | FRAC_W | Luma fractional phase |
| chroma_idx | output | LEN_W | Chroma integer source index |
| chroma_phase | output | FRAC_W | Chroma fractional phase |
| line_done | output | 1 | One-cycle pulse after the last pixel |

## Verification
The bench builds the block with its defaults: LEN_W = 12, FRAC_W = 21 and STEP_W = 26. With these values the divider runs 33 iterations, and the accumulator carries well past the 5 integer bits of the step. Lengths up to 4095 bring the exact 32x downscale boundary within reach (320 against 10 is rejected, 319 against 10 is accepted with a step just under 2^26). Up-, down- and unity-ratio lines of up to 480 pixels are run, including under a stalling ready pattern. These runs exercise the carries into the index, subsampling shifts of 0, 1 and 2, and both filter choices.

// File: rtl/scl_pkg.sv
package scl_pkg;

    typedef enum logic {
        FILT_BILINEAR = 1'b0,
        FILT_COVERAGE = 1'b1
    } filt_e;

endpackage

// File: rtl/scl_ratio_chk.sv
module scl_ratio_chk #(
    parameter int LEN_W = 12,
    parameter int INT_W = 5
) (
    input  logic [LEN_W-1:0] src_len,
    input  logic [LEN_W-1:0] dst_len,
    output logic             is_zero,
    output logic             too_far,
    output logic             downscale,
    output logic             differs
);
    localparam int WIDE_W = LEN_W + INT_W;

    logic [WIDE_W-1:0] src_wide;
    logic [WIDE_W-1:0] dst_limit;

    always_comb begin
        src_wide  = {{INT_W{1'b0}}, src_len};
        dst_limit = {dst_len, {INT_W{1'b0}}};
        is_zero   = (src_len == '0) || (dst_len == '0);
        too_far   = !is_zero && (src_wide >= dst_limit);
        downscale = src_len > dst_len;
        differs   = src_len != dst_len;
    end

endmodule

// File: rtl/scl_step_div.sv
module scl_step_div #(
    parameter int LEN_W  = 12,
    parameter int FRAC_W = 21,
    parameter int STEP_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN_W-1:0]  numer,
    input  logic [LEN_W-1:0]  denom,
    output logic              busy,
    output logic              done,
    output logic [STEP_W-1:0] quotient
);
    localparam int NUM_W = LEN_W + FRAC_W;
    localparam int CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [LEN_W:0]   rem;
        logic [NUM_W-1:0] quo;
        logic [LEN_W-1:0] den;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [LEN_W:0] rem_sh;

    assign rem_sh = {st_q.rem[LEN_W-1:0], st_q.quo[NUM_W-1]};

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
            st_d.rem  = '0;
            st_d.quo  = {numer, {FRAC_W{1'b0}}};
            st_d.den  = denom;
        end else if (st_q.busy) begin
            st_d.quo = {st_q.quo[NUM_W-2:0], 1'b0};
            if (rem_sh >= {1'b0, st_q.den}) begin
                st_d.rem    = rem_sh - {1'b0, st_q.den};
                st_d.quo[0] = 1'b1;
            end else begin
                st_d.rem = rem_sh;
            end
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (st_q.cnt == CNT_W'(NUM_W - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign quotient = st_q.quo[STEP_W-1:0];

    // R2
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.rem < {1'b0, st_q.den}));

endmodule

// File: rtl/scl_phase_acc.sv
module scl_phase_acc #(
    parameter int LEN_W  = 12,
    parameter int FRAC_W = 21,
    parameter int STEP_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [STEP_W-1:0] step,
    output logic [LEN_W-1:0]  idx,
    output logic [FRAC_W-1:0] phase
);
    localparam int ACC_W = LEN_W + FRAC_W + 1;

    logic [ACC_W-1:0] acc_d, acc_q;

    always_comb begin
        acc_d = acc_q;
        if (clear)        acc_d = '0;
        else if (advance) acc_d = acc_q + {{(ACC_W-STEP_W){1'b0}}, step};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign idx   = acc_q[FRAC_W +: LEN_W];
    assign phase = acc_q[FRAC_W-1:0];

    // R8
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (idx == '0 && phase == '0));

    // R8
    acc_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !advance) |=> ($stable(idx) && $stable(phase)));

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int FRAC_W = 21,
    parameter int STEP_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [LEN_W-1:0]  cfg_src_len,
    input  logic [LEN_W-1:0]  cfg_dst_len,
    input  logic [1:0]        cfg_sub_shift,
    input  logic              cfg_is_yuv,
    output logic              cfg_busy,
    output logic              cfg_done,
    output logic              cfg_ok,
    output logic              err_zero,
    output logic              err_range,
    output logic              scale_en,
    output logic              filter_sel,
    output logic [STEP_W-1:0] luma_step,
    output logic [STEP_W-1:0] chroma_step,
    input  logic              line_start,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [LEN_W-1:0]  luma_idx,
    output logic [FRAC_W-1:0] luma_phase,
    output logic [LEN_W-1:0]  chroma_idx,
    output logic [FRAC_W-1:0] chroma_phase,
    output logic              line_done
);
    localparam int INT_W    = STEP_W - FRAC_W;
    localparam int N_PLANES = 2;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              ok;
        logic              ezero;
        logic              erange;
        logic              scale;
        filt_e             filt;
        logic [1:0]        sub;
        logic [LEN_W-1:0]  dst;
        logic [STEP_W-1:0] lstep;
        logic [STEP_W-1:0] cstep;
        logic              active;
        logic [LEN_W-1:0]  cnt;
        logic              ldone;
    } gen_st_t;

    gen_st_t st_d, st_q;

    logic              chk_zero, chk_far, chk_down, chk_diff;
    logic              div_kick, div_busy, div_done;
    logic [STEP_W-1:0] div_quo;
    logic              line_go, px_fire;

    logic [STEP_W-1:0] pl_step  [N_PLANES];
    logic [LEN_W-1:0]  pl_idx   [N_PLANES];
    logic [FRAC_W-1:0] pl_phase [N_PLANES];

    scl_ratio_chk #(.LEN_W(LEN_W), .INT_W(INT_W)) u_chk (
        .src_len   (cfg_src_len),
        .dst_len   (cfg_dst_len),
        .is_zero   (chk_zero),
        .too_far   (chk_far),
        .downscale (chk_down),
        .differs   (chk_diff)
    );

    scl_step_div #(.LEN_W(LEN_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_kick),
        .numer    (cfg_src_len),
        .denom    (cfg_dst_len),
        .busy     (div_busy),
        .done     (div_done),
        .quotient (div_quo)
    );

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        st_d.ldone = 1'b0;
        div_kick   = 1'b0;

        line_go = line_start && st_q.ok && !st_q.busy && !st_q.active && !cfg_start;
        px_fire = st_q.active && out_ready;

        if (cfg_start && !st_q.busy && !st_q.active) begin
            st_d.ezero  = chk_zero;
            st_d.erange = chk_far;
            st_d.scale  = chk_diff || cfg_is_yuv;
            st_d.filt   = chk_down ? FILT_COVERAGE : FILT_BILINEAR;
            st_d.sub    = cfg_sub_shift;
            st_d.dst    = cfg_dst_len;
            st_d.ok     = 1'b0;
            st_d.lstep  = '0;
            st_d.cstep  = '0;
            if (chk_zero || chk_far) begin
                st_d.done = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                div_kick  = 1'b1;
            end
        end else if (st_q.busy && div_done) begin
            st_d.busy  = 1'b0;
            st_d.done  = 1'b1;
            st_d.ok    = 1'b1;
            st_d.lstep = div_quo;
            st_d.cstep = div_quo >> st_q.sub;
        end

        if (line_go) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (px_fire) begin
            st_d.cnt = st_q.cnt + LEN_W'(1);
            if (st_q.cnt == st_q.dst - LEN_W'(1)) begin
                st_d.active = 1'b0;
                st_d.ldone  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pl_step[0] = st_q.lstep;
    assign pl_step[1] = st_q.cstep;

    for (genvar g = 0; g < N_PLANES; g++) begin : g_plane
        scl_phase_acc #(.LEN_W(LEN_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (line_go),
            .advance (px_fire),
            .step    (pl_step[g]),
            .idx     (pl_idx[g]),
            .phase   (pl_phase[g])
        );
    end

    assign cfg_busy     = st_q.busy;
    assign cfg_done     = st_q.done;
    assign cfg_ok       = st_q.ok;
    assign err_zero     = st_q.ezero;
    assign err_range    = st_q.erange;
    assign scale_en     = st_q.scale;
    assign filter_sel   = st_q.filt;
    assign luma_step    = st_q.lstep;
    assign chroma_step  = st_q.cstep;
    assign out_valid    = st_q.active;
    assign line_done    = st_q.ldone;
    assign luma_idx     = pl_idx[0];
    assign luma_phase   = pl_phase[0];
    assign chroma_idx   = pl_idx[1];
    assign chroma_phase = pl_phase[1];

    // R3
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({err_zero, err_range}));

    // R2
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |-> !cfg_busy);

    // R5
    chroma_le_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_done && cfg_ok) |-> (chroma_step <= luma_step));

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(luma_idx) && $stable(luma_phase)
                                       && $stable(chroma_idx) && $stable(chroma_phase)));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_done |-> !out_valid);

    // R11
    no_line_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_busy |-> !out_valid);

endmodule

// File: tb/scl_phase_gen_test.sv
module scl_phase_gen_test;
    localparam int LEN_W  = 12;
    localparam int FRAC_W = 21;
    localparam int STEP_W = 26;
    localparam int NUM_W  = LEN_W + FRAC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_start = 1'b0;
    logic [LEN_W-1:0]  cfg_src_len = '0;
    logic [LEN_W-1:0]  cfg_dst_len = '0;
    logic [1:0]        cfg_sub_shift = '0;
    logic              cfg_is_yuv = 1'b0;
    logic              cfg_busy, cfg_done, cfg_ok, err_zero, err_range, scale_en, filter_sel;
    logic [STEP_W-1:0] luma_step, chroma_step;
    logic              line_start = 1'b0;
    logic              out_ready = 1'b0;
    logic              out_valid, line_done;
    logic [LEN_W-1:0]  luma_idx, chroma_idx;
    logic [FRAC_W-1:0] luma_phase, chroma_phase;

    scl_phase_gen #(.LEN_W(LEN_W), .FRAC_W(FRAC_W), .STEP_W(STEP_W)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_src_len(cfg_src_len),
        .cfg_dst_len(cfg_dst_len), .cfg_sub_shift(cfg_sub_shift), .cfg_is_yuv(cfg_is_yuv),
        .cfg_busy(cfg_busy), .cfg_done(cfg_done), .cfg_ok(cfg_ok), .err_zero(err_zero),
        .err_range(err_range), .scale_en(scale_en), .filter_sel(filter_sel),
        .luma_step(luma_step), .chroma_step(chroma_step), .line_start(line_start),
        .out_ready(out_ready), .out_valid(out_valid), .luma_idx(luma_idx),
        .luma_phase(luma_phase), .chroma_idx(chroma_idx), .chroma_phase(chroma_phase),
        .line_done(line_done)
    );

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        longint li; longint lp; longint ci; longint cp;
    } px_t;
    px_t exp_q[$];

    int     rmode = 0;
    logic [7:0] lfsr = 8'hA5;
    bit     pend_done = 0;
    bit     after_done = 0;
    bit     hold_vld = 0;
    px_t    held;

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // monitor: drives ready, compares accepted pixels against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rmode == 0) out_ready = 1'b1;
            else begin
                out_ready = lfsr[0] & lfsr[2];
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            end
            #1;
            if (pend_done) begin
                chk(line_done === 1'b1 && out_valid === 1'b0, "R10", "line_done after last pixel",
                    longint'(line_done), 1);
                pend_done = 0;
                after_done = 1;
            end else if (after_done) begin
                chk(line_done === 1'b0, "R10", "line_done width", longint'(line_done), 0);
                after_done = 0;
            end
            if (hold_vld) begin
                chk(out_valid === 1'b1 && longint'(luma_idx) == held.li && longint'(luma_phase) == held.lp
                    && longint'(chroma_idx) == held.ci && longint'(chroma_phase) == held.cp,
                    "R9", "hold while stalled luma_phase", longint'(luma_phase), held.lp);
            end
            if (out_valid && out_ready) begin
                hold_vld = 0;
                if (exp_q.size() == 0) begin
                    chk(0, "R9", "unexpected extra pixel", 1, 0);
                end else begin
                    px_t e;
                    e = exp_q.pop_front();
                    chk(longint'(luma_idx) == e.li, "R8", "luma_idx", longint'(luma_idx), e.li);
                    chk(longint'(luma_phase) == e.lp, "R8", "luma_phase", longint'(luma_phase), e.lp);
                    chk(longint'(chroma_idx) == e.ci, "R8", "chroma_idx", longint'(chroma_idx), e.ci);
                    chk(longint'(chroma_phase) == e.cp, "R8", "chroma_phase", longint'(chroma_phase), e.cp);
                    if (exp_q.size() == 0) pend_done = 1;
                end
            end else if (out_valid) begin
                hold_vld = 1;
                held.li = longint'(luma_idx);   held.lp = longint'(luma_phase);
                held.ci = longint'(chroma_idx); held.cp = longint'(chroma_phase);
            end else begin
                hold_vld = 0;
            end
        end
    end

    // driver: load a ratio and check its results
    task automatic configure(int src, int dst, int sh, bit yuv, bit poke,
                             output longint step, output longint cstep);
        bit     zero, far;
        int     n;
        longint unity;
        unity = longint'(1) << FRAC_W;
        zero  = (src == 0) || (dst == 0);
        far   = !zero && (src >= 32 * dst);
        step  = (zero || far) ? 0 : (longint'(src) * unity) / dst;
        cstep = step >> sh;
        @(negedge clk);
        cfg_src_len = LEN_W'(src); cfg_dst_len = LEN_W'(dst);
        cfg_sub_shift = 2'(sh); cfg_is_yuv = yuv; cfg_start = 1'b1;
        @(negedge clk);
        cfg_start = 1'b0;
        n = 1;
        chk(cfg_busy === !(zero || far), "R2", "busy after capture", longint'(cfg_busy),
            longint'(!(zero || far)));
        while (!cfg_done && n < 100) begin
            if (poke && n == 2) line_start = 1'b1;
            @(negedge clk);
            line_start = 1'b0;
            n++;
        end
        if (zero || far)
            chk(n == 1, zero ? "R3" : "R4", "done latency", n, 1);
        else
            chk(n == NUM_W + 2, "R2", "done latency", n, NUM_W + 2);
        chk(err_zero === zero, "R3", "err_zero", longint'(err_zero), longint'(zero));
        chk(err_range === far, "R4", "err_range", longint'(err_range), longint'(far));
        chk(cfg_ok === !(zero || far), "R2", "cfg_ok", longint'(cfg_ok), longint'(!(zero || far)));
        chk(longint'(luma_step) == step, "R2", "luma_step", longint'(luma_step), step);
        chk(longint'(chroma_step) == cstep, "R5", "chroma_step", longint'(chroma_step), cstep);
        if (!zero) begin
            chk(filter_sel === (src > dst), "R6", "filter_sel", longint'(filter_sel), longint'(src > dst));
            chk(scale_en === ((src != dst) || yuv), "R7", "scale_en", longint'(scale_en),
                longint'((src != dst) || yuv));
        end
        chk(out_valid === 1'b0, "R11", "no line from start while busy", longint'(out_valid), 0);
        @(negedge clk);
        chk(cfg_done === 1'b0, "R2", "cfg_done width", longint'(cfg_done), 0);
    endtask

    task automatic run_line(int dst, longint step, longint cstep, int mode);
        int guard;
        longint mask;
        mask = (longint'(1) << FRAC_W) - 1;
        for (int k = 0; k < dst; k++) begin
            px_t e;
            e.li = ((longint'(k) * step) >> FRAC_W) & ((longint'(1) << LEN_W) - 1);
            e.lp = (longint'(k) * step) & mask;
            e.ci = ((longint'(k) * cstep) >> FRAC_W) & ((longint'(1) << LEN_W) - 1);
            e.cp = (longint'(k) * cstep) & mask;
            exp_q.push_back(e);
        end
        rmode = mode;
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        #2;
        chk(out_valid === 1'b1, "R9", "valid after line_start", longint'(out_valid), 1);
        guard = 0;
        while ((exp_q.size() != 0 || pend_done || after_done) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(exp_q.size() == 0, "R10", "pixels left in line", exp_q.size(), 0);
        @(negedge clk);
        #2;
        chk(out_valid === 1'b0, "R10", "valid after line", longint'(out_valid), 0);
        rmode = 0;
    endtask

    task automatic ignored_line();
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int i = 0; i < 4; i++) begin
            #2;
            chk(out_valid === 1'b0, "R11", "line_start ignored", longint'(out_valid), 0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        longint s, c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(cfg_busy === 0 && cfg_done === 0 && cfg_ok === 0, "R1", "cfg flags", longint'(cfg_ok), 0);
        chk(err_zero === 0 && err_range === 0, "R1", "err flags", longint'(err_zero), 0);
        chk(out_valid === 0 && line_done === 0, "R1", "line flags", longint'(out_valid), 0);
        chk(luma_step == 0 && chroma_step == 0, "R1", "steps", longint'(luma_step), 0);

        configure(100, 200, 0, 0, 1, s, c);   // upscale, line_start poked while busy (R11)
        run_line(200, s, c, 0);
        configure(640, 480, 1, 1, 0, s, c);   // downscale, chroma by two
        run_line(480, s, c, 1);
        configure(64, 64, 0, 0, 0, s, c);     // unity RGB, scale off
        run_line(64, s, c, 0);
        configure(64, 64, 2, 1, 0, s, c);     // unity YUV, chroma by four
        run_line(64, s, c, 1);
        configure(0, 10, 0, 0, 0, s, c);      // R3
        ignored_line();
        configure(10, 0, 0, 0, 0, s, c);      // R3
        configure(320, 10, 0, 0, 0, s, c);    // R4 exact limit rejected
        ignored_line();
        configure(319, 10, 1, 1, 0, s, c);    // R4 just under limit accepted
        run_line(10, s, c, 1);
        configure(7, 3, 0, 0, 0, s, c);
        run_line(3, s, c, 1);
        summary();
    end

endmodule